// File: doc/BRIEF.md
# Clock Output Enable and Power-Down Control

This block decides, for each of twelve differential clock output pairs, how the analog output driver behaves. Each pair has two enables. One is an active-low enable pin. The other is an enable bit held in the register file. A pair runs normally only when both enables agree. Outputs 10 and 11 share one enable pin.

A power-down input overrides both enables. While it is high, every pair goes to a power-down state. A register bit chooses between two power-down states: the true leg driven at twice the reference current, or the true leg left floating. In both states the complement leg is held low. The block emits a 2-bit drive code per pair for the driver stage.

The block also captures three strap pins once after reset: PLL bypass, bandwidth select and frequency select. It holds them and returns them for readback. From the frequency-select strap it forms the reset value of the ratio-control register. It supplies the synchronized enable-pin states as two readback bytes.

Top module: `clkout_enable_ctl`

## Requirements
- R1: A pair's drive code is 00 (normal) only when its synchronized enable pin is 0 and its register enable bit is 1. Any other combination gives 01 (high impedance). Pair i occupies bits [2i+1:2i] of `out_mode`.
- R2: Pairs 0 to 9 follow enable pin i (`oe_pin_n[i]`). Pairs 10 and 11 both follow the shared pin `oe_pin_n[10]`.
- R3: While power-down is high, every pair's code is 10 when `pd_drive_sel` is 1 (drive at twice the reference current) and 11 when it is 0 (float). This holds whatever the enables are.
- R4: `rb_pins_lo[i]` returns the synchronized state of enable pin i, for i from 0 to 7.
- R5: `rb_pins_hi` bits 0, 1 and 2 return pins 8, 9 and the shared 10/11 pin. Bits 3 and 4 read 0. Bits 5, 6 and 7 return the captured bypass strap, bandwidth strap and frequency-select strap.
- R6: `rv_ratio_byte` has bit 0 = 1, bit 1 = NOT fs, bit 2 = 0, bit 3 = fs, bit 4 = fs, and bits 5 to 7 = 1. Here fs is the captured frequency-select strap. This gives 0xE3 for fs = 0 and 0xF9 for fs = 1.
- R7: The straps are captured on the first rising clock edge after reset is released. They then hold until the next reset, whatever the strap pins do.
- R8: A change on an enable pin or on power-down reaches `out_mode` on the third rising edge after it is applied, through two synchronizer flops and one output register. A change on a register enable bit or on `pd_drive_sel` reaches `out_mode` on the next rising edge.
- R9: While reset is high, every pair's code is 01, `rb_pins_lo` is 0xFF and the captured straps read 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_pin_n | input | 11 | Active-low enable pins; index 10 is the shared pin for pairs 10 and 11 |
| pwrdn | input | 1 | Asynchronous power-down request, active high |
| strap_bypass_n | input | 1 | PLL-bypass strap (0 = bypass) |
| strap_bw | input | 1 | Bandwidth-select strap pin |
| strap_fs | input | 1 | Frequency-select strap |
| reg_out_en | input | 12 | Register-file enable bit per pair, 1 = enabled |
| pd_drive_sel | input | 1 | Power-down choice: 1 = drive at twice the reference current, 0 = float |
| out_mode | output | 24 | Registered 2-bit drive code per pair |
| rb_pins_lo | output | 8 | Readback of enable pins 0 to 7 |
| rb_pins_hi | output | 8 | Readback of pins 8, 9, 10/11 and the captured straps |
| rv_ratio_byte | output | 8 | Strap-dependent reset value for the ratio-control register |

## Verification
A wrong pin-to-pair mapping or a wrong enable combination shows up as a wrong 2-bit code on one specific pair. It appears three edges after a pin change, or one edge after a change to a register bit. The bench therefore sweeps all 2048 pin patterns and compares all twelve codes. A lost priority of power-down over the enables shows as a 00 or 01 code while power-down is high. A strap latch that keeps following its pins shows in `rb_pins_hi` and `rv_ratio_byte` a few cycles after the straps toggle. The bench samples these outputs once on the capture edge and again after the straps have changed.

// File: rtl/clkout_ctl_pkg.sv
package clkout_ctl_pkg;
  typedef enum logic [1:0] {
    DRV_NORMAL  = 2'b00,
    DRV_HIZ     = 2'b01,
    DRV_PD_CUR  = 2'b10,
    DRV_PD_FLT  = 2'b11
  } drv_mode_e;
endpackage

// File: rtl/clkout_sync.sv
module clkout_sync #(
  parameter int WIDTH   = 1,
  parameter int STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= {WIDTH{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/clkout_strap_latch.sv
module clkout_strap_latch (
  input  logic clk,
  input  logic rst,
  input  logic bypass_n_in,
  input  logic bw_in,
  input  logic fs_in,
  output logic bypass_n_q,
  output logic bw_q,
  output logic fs_q
);
  logic taken;

  always_ff @(posedge clk) begin
    if (rst) begin
      taken      <= 1'b0;
      bypass_n_q <= 1'b0;
      bw_q       <= 1'b0;
      fs_q       <= 1'b0;
    end else if (!taken) begin
      taken      <= 1'b1;
      bypass_n_q <= bypass_n_in;
      bw_q       <= bw_in;
      fs_q       <= fs_in;
    end
  end

  // R7
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (taken && $past(taken)) |-> ($stable(fs_q) && $stable(bw_q) && $stable(bypass_n_q)));
endmodule

// File: rtl/clkout_mode_gen.sv
module clkout_mode_gen
  import clkout_ctl_pkg::*;
#(
  parameter int NUM_OUT = 12,
  parameter int NUM_PIN = 11
) (
  input  logic [NUM_PIN-1:0]   pin_n,
  input  logic [NUM_OUT-1:0]   reg_en,
  input  logic                 pd,
  input  logic                 pd_drive,
  output logic [2*NUM_OUT-1:0] mode
);
  localparam int LAST_PIN = NUM_PIN - 1;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_pair
    localparam int PIDX = (i < LAST_PIN) ? i : LAST_PIN;
    drv_mode_e m;
    always_comb begin
      if (pd)
        m = pd_drive ? DRV_PD_CUR : DRV_PD_FLT;
      else if (!pin_n[PIDX] && reg_en[i])
        m = DRV_NORMAL;
      else
        m = DRV_HIZ;
    end
    assign mode[2*i +: 2] = m;
  end
endmodule

// File: rtl/clkout_enable_ctl.sv
module clkout_enable_ctl
  import clkout_ctl_pkg::*;
#(
  parameter int NUM_OUT     = 12,
  parameter int SHARED_FROM = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SHARED_FROM:0] oe_pin_n,
  input  logic                 pwrdn,
  input  logic                 strap_bypass_n,
  input  logic                 strap_bw,
  input  logic                 strap_fs,
  input  logic [NUM_OUT-1:0]   reg_out_en,
  input  logic                 pd_drive_sel,
  output logic [2*NUM_OUT-1:0] out_mode,
  output logic [7:0]           rb_pins_lo,
  output logic [7:0]           rb_pins_hi,
  output logic [7:0]           rv_ratio_byte
);
  localparam int NUM_PIN = SHARED_FROM + 1;
  localparam int LO_PINS = 8;

  logic [NUM_PIN-1:0]   pin_s;
  logic                 pd_s;
  logic [2*NUM_OUT-1:0] mode_d;
  logic                 byp_q, bw_q, fs_q;
  logic [NUM_OUT-1:0]   mode_hi, mode_lo;

  clkout_sync #(.WIDTH(NUM_PIN), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst(rst), .d(oe_pin_n), .q(pin_s));

  clkout_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pd_sync (
    .clk(clk), .rst(rst), .d(pwrdn), .q(pd_s));

  clkout_strap_latch u_strap (
    .clk(clk), .rst(rst),
    .bypass_n_in(strap_bypass_n), .bw_in(strap_bw), .fs_in(strap_fs),
    .bypass_n_q(byp_q), .bw_q(bw_q), .fs_q(fs_q));

  clkout_mode_gen #(.NUM_OUT(NUM_OUT), .NUM_PIN(NUM_PIN)) u_mode (
    .pin_n(pin_s), .reg_en(reg_out_en), .pd(pd_s), .pd_drive(pd_drive_sel),
    .mode(mode_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_mode   <= {NUM_OUT{DRV_HIZ}};
      rb_pins_lo <= '1;
    end else begin
      out_mode   <= mode_d;
      rb_pins_lo <= pin_s[LO_PINS-1:0];
    end
  end

  assign rb_pins_hi    = {fs_q, bw_q, byp_q, 2'b00, pin_s[NUM_PIN-1:LO_PINS]};
  assign rv_ratio_byte = {3'b111, fs_q, fs_q, 1'b0, ~fs_q, 1'b1};

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_split
    assign mode_hi[i] = out_mode[2*i+1];
    assign mode_lo[i] = out_mode[2*i];
  end

  // R3
  pd_override_chk: assert property (@(posedge clk) disable iff (rst)
    pd_s |=> (&mode_hi));

  // R3
  pd_drive_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (pd_s && pd_drive_sel) |=> (mode_lo == '0));

  // R1
  pin_off_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (!pd_s && pin_s[0]) |=> (out_mode[1:0] == DRV_HIZ));

  // R4
  readback_lo_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rb_pins_lo == $past(pin_s[LO_PINS-1:0])));
endmodule

// File: tb/test_clkout_enable_ctl.sv
module test_clkout_enable_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] oe_pin_n = '1;
  logic        pwrdn = 1'b0;
  logic        strap_bypass_n = 1'b0, strap_bw = 1'b0, strap_fs = 1'b0;
  logic [11:0] reg_out_en = '1;
  logic        pd_drive_sel = 1'b0;
  logic [23:0] out_mode;
  logic [7:0]  rb_pins_lo, rb_pins_hi, rv_ratio_byte;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clkout_enable_ctl i_clkout_enable_ctl (
    .clk(clk), .rst(rst), .oe_pin_n(oe_pin_n), .pwrdn(pwrdn),
    .strap_bypass_n(strap_bypass_n), .strap_bw(strap_bw), .strap_fs(strap_fs),
    .reg_out_en(reg_out_en), .pd_drive_sel(pd_drive_sel),
    .out_mode(out_mode), .rb_pins_lo(rb_pins_lo), .rb_pins_hi(rb_pins_hi),
    .rv_ratio_byte(rv_ratio_byte));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_mode(input logic [10:0] p, input logic [11:0] e,
                                           input logic pd, input logic sel);
    logic [23:0] r;
    for (int i = 0; i < 12; i++) begin
      int pi = (i < 10) ? i : 10;
      if (pd)                    r[2*i +: 2] = sel ? 2'b10 : 2'b11;
      else if (!p[pi] && e[i])   r[2*i +: 2] = 2'b00;
      else                       r[2*i +: 2] = 2'b01;
    end
    return r;
  endfunction

  task automatic settle3;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    logic [2:0] st;
    // R9 reset state
    repeat (3) @(posedge clk); #1;
    chk("R9 mode in reset", out_mode, {12{2'b01}});
    chk("R9 rb_lo in reset", rb_pins_lo, 8'hFF);
    chk("R9 straps in reset", rb_pins_hi[7:5], 3'b000);

    // R6 R7 strap sweep
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      rst = 1'b1;
      {strap_fs, strap_bw, strap_bypass_n} = s[2:0];
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk); #1;
      st = s[2:0];
      chk("R7 strap captured", rb_pins_hi[7:5], st);
      chk("R6 ratio reset value", rv_ratio_byte,
          {3'b111, st[2], st[2], 1'b0, ~st[2], 1'b1});
      @(negedge clk);
      {strap_fs, strap_bw, strap_bypass_n} = ~s[2:0];
      settle3;
      chk("R7 strap held", rb_pins_hi[7:5], st);
      chk("R6 ratio held", rv_ratio_byte,
          {3'b111, st[2], st[2], 1'b0, ~st[2], 1'b1});
    end

    // R1 R2 R3 R4 R5 exhaustive pin sweep
    for (int v = 0; v < 2048; v++) begin
      logic [11:0] e;
      logic pd, sel;
      e   = 12'((v * 113) ^ (v >> 3) ^ 12'hA5C);
      pd  = (v % 7) == 3;
      sel = v[4];
      @(negedge clk);
      oe_pin_n = v[10:0]; reg_out_en = e; pwrdn = pd; pd_drive_sel = sel;
      settle3;
      chk(pd ? "R3 power-down code" : "R1 R2 enable combine", out_mode,
          exp_mode(v[10:0], e, pd, sel));
      chk("R4 pin readback lo", rb_pins_lo, v[7:0]);
      chk("R5 pin readback hi", rb_pins_hi[4:0], {2'b00, v[10:8]});
    end

    // R8 pin latency
    @(negedge clk);
    oe_pin_n = '0; reg_out_en = '1; pwrdn = 1'b0;
    settle3;
    chk("R8 base all normal", out_mode, 24'h0);
    @(negedge clk);
    oe_pin_n[10] = 1'b1;
    repeat (2) @(posedge clk); #1;
    chk("R8 pin not yet at edge 2", out_mode, 24'h0);
    @(posedge clk); #1;
    chk("R2 R8 shared pin at edge 3", out_mode, {4'b0101, 20'h0});
    // R8 register bit latency
    @(negedge clk);
    reg_out_en[3] = 1'b0;
    @(posedge clk); #1;
    chk("R8 reg bit next edge", out_mode, {4'b0101, 12'h0, 2'b01, 6'h0});
    // R8 power-down latency and R3 selection change
    @(negedge clk);
    pwrdn = 1'b1; pd_drive_sel = 1'b1;
    repeat (2) @(posedge clk); #1;
    chk("R8 pd not yet at edge 2", out_mode, {4'b0101, 12'h0, 2'b01, 6'h0});
    @(posedge clk); #1;
    chk("R3 R8 pd drive at edge 3", out_mode, {12{2'b10}});
    @(negedge clk);
    pd_drive_sel = 1'b0;
    @(posedge clk); #1;
    chk("R3 pd float", out_mode, {12{2'b11}});

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule